// File: doc/BRIEF.md
# Magnetic Angle Sensor Poller

This block is an SPI master that reads one angle sample from a 14-bit magnetic rotary position sensor each time it is triggered. A sample is two chip-select-framed 16-bit reads. The first read fetches sensor register 0x03 and the second fetches register 0x04. The block keeps only the data byte returned in the second half of each frame and joins the two bytes into a 16-bit word. The word holds the angle in its upper fourteen bits, a no-magnet flag in bit 1 and an even-parity bit in bit 0.

A word whose parity fails is dropped and a parity error is counted. A word with correct parity but the no-magnet flag set is also dropped, and a separate no-magnet count is kept for it. Any other word updates the angle output and raises a one-cycle valid strobe. One full turn spans 16384 angle steps. The serial clock comes from the system clock through a parameterised divider. The chip-select guard delays and the gap between the two frames are set by parameters in units of serial-clock half-periods.

Top module: `angle_spi_reader`

## Requirements
- R1: A trigger seen while the block is idle starts a sample. busy is high from the next cycle until the result is posted. A trigger seen while busy is ignored and does not start a further sample.
- R2: Each sample sends two commands, 16'h8300 and then 16'h8400, MSB first, in SPI mode 3. sclk idles high, mosi changes after a falling sclk edge, and miso is sampled on the rising edge.
- R3: cs_n goes low exactly twice per sample, once around each command, and stays high while idle. sclk is high whenever cs_n is high.
- R4: The last 8 bits received in the first frame form word[15:8] and the last 8 bits of the second frame form word[7:0]. The first 8 bits received in each frame have no effect.
- R5: If the XOR of all 16 word bits is 1, parity_error pulses, the parity error count rises by one and angle keeps its value.
- R6: If parity holds and word bit 1 is 1, no_magnet pulses, the no-magnet count rises by one and angle keeps its value.
- R7: If parity holds and word bit 1 is 0, angle becomes word[15:2] and angle_valid pulses.
- R8: Exactly one of angle_valid, parity_error and no_magnet pulses per sample, for one cycle, in the first cycle in which busy is low again.
- R9: Both counts are CNT_W bits wide and stop at all-ones instead of wrapping.
- R10: Reset clears angle and both counts, drives cs_n and sclk high and busy low, and leaves all three strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Start one sample when idle |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Sample in progress |
| angle | output | 14 | Last accepted angle |
| angle_valid | output | 1 | One-cycle strobe: new angle posted |
| parity_error | output | 1 | One-cycle strobe: sample failed parity |
| no_magnet | output | 1 | One-cycle strobe: sensor reported no magnet |
| parity_err_count | output | CNT_W | Saturating count of parity failures |
| no_magnet_count | output | CNT_W | Saturating count of no-magnet samples |

## Verification
The hardest situation to reach from the ports is a saturated count. Making the count move at all already needs a sensor reply whose two data bytes, taken from different frames, combine into a word with a specific parity and flag, and saturation needs many such samples in a row. The bench uses a reactive sensor model that serves a chosen word split across the two frames, with random filler in the ignored upper bytes. It also narrows CNT_W so that a run of forced parity and no-magnet words drives both counts into saturation within a few hundred samples. Stray triggers are injected in the middle of samples to show that they are ignored.

// File: rtl/angle_spi_pkg.sv
package angle_spi_pkg;

   localparam int FRAME_W = 16;
   localparam int BYTE_W  = 8;
   localparam int ANGLE_W = 14;

   // read flag in bit 15, register number in bits 14:8
   localparam logic [FRAME_W-1:0] CMD_HI_REG = 16'h8300;
   localparam logic [FRAME_W-1:0] CMD_LO_REG = 16'h8400;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,    // cs_n high, guard before it falls
      ST_SETUP,  // cs_n low, guard before first sclk edge
      ST_XFER,   // shifting
      ST_HOLD,   // cs_n low, guard after last sclk edge
      ST_POST,   // cs_n high, guard after it rises
      ST_GAP,    // idle spacing between the two frames
      ST_DONE    // hand the word to the checker
   } seq_state_t;

endpackage

// File: rtl/spi_mode3_shifter.sv
module spi_mode3_shifter
   import angle_spi_pkg::*;
#(
   parameter int TX_W   = FRAME_W,
   parameter int KEEP_W = BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic              tick,
   input  logic [TX_W-1:0]   tx_word,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic [KEEP_W-1:0] rx_tail,
   output logic              done
);

   localparam int CW = $clog2(TX_W + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(TX_W);

   logic [TX_W-1:0] sh_q;
   logic [CW-1:0]   bit_q;

   generate
      if (KEEP_W > TX_W) begin : g_bad_keep
         $error("KEEP_W must not exceed TX_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk    <= 1'b1;
         mosi    <= 1'b0;
         sh_q    <= '0;
         bit_q   <= '0;
         rx_tail <= '0;
      end else if (load) begin
         sh_q  <= tx_word;
         sclk  <= 1'b1;
         bit_q <= '0;
      end else if (run && tick && (bit_q != LAST_CNT)) begin
         if (sclk) begin
            sclk <= 1'b0;
            mosi <= sh_q[TX_W-1];
            sh_q <= {sh_q[TX_W-2:0], 1'b0};
         end else begin
            sclk    <= 1'b1;
            // the shallow register keeps only the trailing bits of the frame
            rx_tail <= {rx_tail[KEEP_W-2:0], miso};
            bit_q   <= bit_q + 1'b1;
         end
      end
   end

   assign done = (bit_q == LAST_CNT);

   // R2
   mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
   import angle_spi_pkg::*;
#(
   parameter int CLK_DIV      = 4,
   parameter int GUARD_HALVES = 2,
   parameter int GAP_HALVES   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trigger,
   input  logic               xfer_done,
   output logic               busy,
   output logic               cs_n,
   output logic               tick,
   output logic               load,
   output logic               run,
   output logic               frame_sel,
   output logic               cap_en,
   output logic               eval,
   output logic [FRAME_W-1:0] tx_word
);

   localparam int MAXH = (GUARD_HALVES > GAP_HALVES) ? GUARD_HALVES : GAP_HALVES;
   localparam int HW   = $clog2(MAXH + 1);
   localparam logic [HW-1:0] GUARD_LAST = HW'(GUARD_HALVES - 1);
   localparam logic [HW-1:0] GAP_LAST   = HW'(GAP_HALVES - 1);

   seq_state_t state_q, state_d;
   logic [HW-1:0] half_q;
   logic          active;
   logic          guard_end;
   logic          in_guard;

   assign active = (state_q != ST_IDLE);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (GUARD_HALVES < 1 || GAP_HALVES < 1) begin : g_bad_guard
         $error("guard and gap lengths must be at least one half-period");
      end
      if (CLK_DIV == 1) begin : g_div_bypass
         assign tick = active;
      end else begin : g_div_count
         localparam int DW = $clog2(CLK_DIV);
         localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !active || div_q == DIV_LAST) div_q <= '0;
            else                                        div_q <= div_q + 1'b1;
         end
         assign tick = active && (div_q == DIV_LAST);
      end
   endgenerate

   assign in_guard  = (state_q == ST_PRE) || (state_q == ST_SETUP) || (state_q == ST_HOLD) ||
                      (state_q == ST_POST) || (state_q == ST_GAP);
   assign guard_end = in_guard && tick &&
                      (half_q == ((state_q == ST_GAP) ? GAP_LAST : GUARD_LAST));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (trigger)   state_d = ST_PRE;
         ST_PRE:   if (guard_end) state_d = ST_SETUP;
         ST_SETUP: if (guard_end) state_d = ST_XFER;
         ST_XFER:  if (xfer_done) state_d = ST_HOLD;
         ST_HOLD:  if (guard_end) state_d = ST_POST;
         ST_POST:  if (guard_end) state_d = frame_sel ? ST_DONE : ST_GAP;
         ST_GAP:   if (guard_end) state_d = ST_PRE;
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         half_q    <= '0;
         frame_sel <= 1'b0;
         cs_n      <= 1'b1;
      end else begin
         state_q <= state_d;
         if (state_d != state_q) half_q <= '0;
         else if (tick)          half_q <= half_q + 1'b1;
         if (state_q == ST_IDLE && state_d == ST_PRE) frame_sel <= 1'b0;
         else if (state_q == ST_GAP && state_d == ST_PRE) frame_sel <= 1'b1;
         cs_n <= !((state_d == ST_SETUP) || (state_d == ST_XFER) || (state_d == ST_HOLD));
      end
   end

   assign busy    = active;
   assign load    = (state_q == ST_PRE);
   assign run     = (state_q == ST_XFER);
   assign cap_en  = (state_q == ST_XFER) && xfer_done;
   assign eval    = (state_q == ST_DONE);
   assign tx_word = frame_sel ? CMD_LO_REG : CMD_HI_REG;

   // R1
   trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trigger) |=> busy);

   // R3
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   // R3
   cs_stable_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !cs_n);

endmodule

// File: rtl/sample_checker.sv
module sample_checker
   import angle_spi_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic               frame_sel,
   input  logic [BYTE_W-1:0]  rx_byte,
   input  logic               eval,
   output logic [ANGLE_W-1:0] angle,
   output logic               angle_valid,
   output logic               parity_error,
   output logic               no_magnet,
   output logic [CNT_W-1:0]   perr_count,
   output logic [CNT_W-1:0]   nomag_count
);

   localparam int NCNT = 2;
   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] hi_q, lo_q;
   logic [WORD_W-1:0] word;
   logic              par_bad;
   logic              mag_bad;
   logic [NCNT-1:0]   bump;
   logic [NCNT-1:0][CNT_W-1:0] cnt_bus;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (ANGLE_W + 2 != WORD_W) begin : g_bad_angle
         $error("angle must fill the word above the flag and parity bits");
      end
   endgenerate

   assign word    = {hi_q, lo_q};
   assign par_bad = ^word;
   assign mag_bad = word[1];
   assign bump[0] = eval && par_bad;
   assign bump[1] = eval && !par_bad && mag_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q         <= '0;
         lo_q         <= '0;
         angle        <= '0;
         angle_valid  <= 1'b0;
         parity_error <= 1'b0;
         no_magnet    <= 1'b0;
      end else begin
         if (cap_en) begin
            if (frame_sel) lo_q <= rx_byte;
            else           hi_q <= rx_byte;
         end
         angle_valid  <= eval && !par_bad && !mag_bad;
         parity_error <= bump[0];
         no_magnet    <= bump[1];
         if (eval && !par_bad && !mag_bad) angle <= word[WORD_W-1:2];
      end
   end

   for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      logic [CNT_W-1:0] c_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                      c_q <= '0;
         else if (bump[g] && (c_q != '1)) c_q <= c_q + 1'b1;
      end
      assign cnt_bus[g] = c_q;
   end

   assign perr_count  = cnt_bus[0];
   assign nomag_count = cnt_bus[1];

   // R8
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({angle_valid, parity_error, no_magnet}));

   // R7
   angle_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(angle) |-> angle_valid);

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_count >= $past(perr_count)) && (nomag_count >= $past(nomag_count)));

   // R5
   perr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_count != $past(perr_count)) |-> parity_error);

endmodule

// File: rtl/angle_spi_reader.sv
module angle_spi_reader
   import angle_spi_pkg::*;
#(
   parameter int CLK_DIV      = 4,
   parameter int GUARD_HALVES = 2,
   parameter int GAP_HALVES   = 4,
   parameter int CNT_W        = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trigger,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic               cs_n,
   output logic               busy,
   output logic [ANGLE_W-1:0] angle,
   output logic               angle_valid,
   output logic               parity_error,
   output logic               no_magnet,
   output logic [CNT_W-1:0]   parity_err_count,
   output logic [CNT_W-1:0]   no_magnet_count
);

   logic               tick, load, run, frame_sel, cap_en, eval, xfer_done;
   logic [FRAME_W-1:0] tx_word;
   logic [BYTE_W-1:0]  rx_byte;

   frame_sequencer #(
      .CLK_DIV      (CLK_DIV),
      .GUARD_HALVES (GUARD_HALVES),
      .GAP_HALVES   (GAP_HALVES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .trigger   (trigger),
      .xfer_done (xfer_done),
      .busy      (busy),
      .cs_n      (cs_n),
      .tick      (tick),
      .load      (load),
      .run       (run),
      .frame_sel (frame_sel),
      .cap_en    (cap_en),
      .eval      (eval),
      .tx_word   (tx_word)
   );

   spi_mode3_shifter #(
      .TX_W   (FRAME_W),
      .KEEP_W (BYTE_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .run     (run),
      .tick    (tick),
      .tx_word (tx_word),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .rx_tail (rx_byte),
      .done    (xfer_done)
   );

   sample_checker #(
      .CNT_W (CNT_W)
   ) u_chk (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_en       (cap_en),
      .frame_sel    (frame_sel),
      .rx_byte      (rx_byte),
      .eval         (eval),
      .angle        (angle),
      .angle_valid  (angle_valid),
      .parity_error (parity_error),
      .no_magnet    (no_magnet),
      .perr_count   (parity_err_count),
      .nomag_count  (no_magnet_count)
   );

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R8
   result_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (angle_valid || parity_error || no_magnet) |-> !busy);

endmodule

// File: tb/angle_spi_reader_tb.sv
module angle_spi_reader_tb;

   localparam int CW = 4;
   localparam logic [CW-1:0] CMAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trigger = 1'b0;
   logic miso = 1'b1;
   logic sclk, mosi, cs_n, busy, angle_valid, parity_error, no_magnet;
   logic [13:0]   angle;
   logic [CW-1:0] parity_err_count, no_magnet_count;

   always #2 clk = ~clk;

   angle_spi_reader #(
      .CLK_DIV(2), .GUARD_HALVES(2), .GAP_HALVES(3), .CNT_W(CW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .trigger(trigger), .sclk(sclk), .mosi(mosi),
      .miso(miso), .cs_n(cs_n), .busy(busy), .angle(angle),
      .angle_valid(angle_valid), .parity_error(parity_error), .no_magnet(no_magnet),
      .parity_err_count(parity_err_count), .no_magnet_count(no_magnet_count)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [15:0] reply [2];
   logic [15:0] cmd_seen [2];
   logic [15:0] cap;
   int fidx = 0;
   int bidx = 15;
   int cs_falls = 0;
   int clk_viol = 0;

   logic [13:0]   exp_angle = '0;
   logic [CW-1:0] exp_pc = '0;
   logic [CW-1:0] exp_nc = '0;

   // sensor model: answers on falling sclk, records mosi on rising sclk
   always @(negedge cs_n) begin
      bidx = 15;
      cap = '0;
      cs_falls++;
   end
   always @(negedge sclk) if (!cs_n && bidx >= 0) begin
      miso = reply[fidx][bidx];
      bidx--;
   end
   always @(posedge sclk) if (!cs_n) cap = {cap[14:0], mosi};
   always @(posedge cs_n) if (rst_n) begin
      cmd_seen[fidx] = cap;
      fidx = fidx ^ 1;
   end
   always @(negedge clk) if (rst_n && cs_n && !sclk) clk_viol++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] make_word(input int kind, input logic [15:0] r);
      logic [15:0] w;
      w = r;
      w[1] = (kind == 1);
      w[0] = ^w[15:1];
      if (kind == 2) w[0] = ~w[0];
      return w;
   endfunction

   task automatic run_sample(input logic [15:0] w, input logic [7:0] junk_a,
                             input logic [7:0] junk_b, input bit stray);
      int n;
      bit pe, nm;
      reply[0] = {junk_a, w[15:8]};
      reply[1] = {junk_b, w[7:0]};
      fidx = 0;
      cs_falls = 0;
      cmd_seen[0] = '0;
      cmd_seen[1] = '0;
      @(negedge clk) trigger = 1'b1;
      @(negedge clk) trigger = 1'b0;
      chk(busy == 1'b1, "R1 busy after trigger", busy, 1);
      n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
         if (stray && n == 40) trigger = 1'b1;
         else trigger = 1'b0;
      end
      trigger = 1'b0;
      chk(n < 3000, "R1 sample completes", n, 0);
      pe = ^w;
      nm = !pe && w[1];
      if (pe) begin
         if (exp_pc != CMAX) exp_pc = exp_pc + 1'b1;
      end else if (nm) begin
         if (exp_nc != CMAX) exp_nc = exp_nc + 1'b1;
      end else begin
         exp_angle = w[15:2];
      end
      chk(parity_error == pe, "R5 parity_error strobe", parity_error, pe);
      chk(no_magnet == nm, "R6 no_magnet strobe", no_magnet, nm);
      chk(angle_valid == (!pe && !nm), "R7 angle_valid strobe", angle_valid, !pe && !nm);
      chk(angle == exp_angle, "R7 R4 angle value", angle, exp_angle);
      chk(parity_err_count == exp_pc, "R5 R9 parity count", parity_err_count, exp_pc);
      chk(no_magnet_count == exp_nc, "R6 R9 no-magnet count", no_magnet_count, exp_nc);
      chk(cmd_seen[0] == 16'h8300, "R2 first command", cmd_seen[0], 16'h8300);
      chk(cmd_seen[1] == 16'h8400, "R2 second command", cmd_seen[1], 16'h8400);
      chk(cs_falls == 2, "R3 two chip-select frames", cs_falls, 2);
      @(negedge clk);
      chk({angle_valid, parity_error, no_magnet} == 3'b000, "R8 strobes last one cycle",
          {angle_valid, parity_error, no_magnet}, 0);
      chk(busy == 1'b0, "R1 stray trigger ignored", busy, 0);
      chk(cs_n == 1'b1, "R3 cs_n high when idle", cs_n, 1);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(cs_n == 1'b1, "R10 cs_n in reset", cs_n, 1);
      chk(sclk == 1'b1, "R10 sclk in reset", sclk, 1);
      chk(busy == 1'b0, "R10 busy in reset", busy, 0);
      chk(angle == '0, "R10 angle in reset", angle, 0);
      chk(parity_err_count == '0 && no_magnet_count == '0, "R10 counts in reset",
          {parity_err_count, no_magnet_count}, 0);
      chk({angle_valid, parity_error, no_magnet} == 3'b000, "R10 strobes in reset",
          {angle_valid, parity_error, no_magnet}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1, "R1 R3 idle without trigger", {busy, cs_n}, 1);

      // directed corners
      run_sample(16'hFFFC, 8'h00, 8'hFF, 1'b0); // R7 full-scale angle
      run_sample(16'h0000, 8'hFF, 8'hFF, 1'b1); // R7 zero angle, R4 junk ignored
      run_sample(16'hFFFF, 8'hA5, 8'h5A, 1'b0); // R6 flag set, parity even
      run_sample(16'h0001, 8'h00, 8'h00, 1'b1); // R5 odd parity
      run_sample(16'h8006, 8'h3C, 8'hC3, 1'b0); // R5 odd with flag set: parity wins

      // random mix
      for (int i = 0; i < 120; i++) begin
         int k;
         logic [31:0] r;
         k = $urandom_range(0, 2);
         r = $urandom;
         run_sample(make_word(k, r[15:0]), r[23:16], r[31:24], (i % 5) == 0);
      end

      // drive both counts into saturation (R9)
      for (int i = 0; i < 2 * (1 << CW); i++) begin
         logic [31:0] r;
         r = $urandom;
         run_sample(make_word(2, r[15:0]), r[23:16], r[31:24], 1'b0);
         run_sample(make_word(1, r[31:16]), r[7:0], r[15:8], 1'b0);
      end
      chk(parity_err_count == CMAX, "R9 parity count saturated", parity_err_count, CMAX);
      chk(no_magnet_count == CMAX, "R9 no-magnet count saturated", no_magnet_count, CMAX);
      run_sample(16'h1234 | 16'h0000, 8'h11, 8'h22, 1'b0);
      chk(clk_viol == 0, "R3 sclk high while cs_n high", clk_viol, 0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule